// File: doc/BRIEF.md
# Sub-Audio Tone Generator

This block produces a stream of signed sine samples at one of 47 selectable sub-audio signalling frequencies, for use on a radio transmit path. It runs from a 4 MHz system clock. A prescaler turns that clock into an 8 kHz sample strobe. On each strobe, a 16-bit phase accumulator advances by a per-tone increment read from a computed table, and its top 8 bits address a 256-point sine table.

A 6-bit tone code chooses the frequency. Code 0 and codes 48 to 63 mean "no tone". When transmit is off, or a no-tone code is selected, every sample is mid-scale (zero) and the accumulator is cleared, so a new tone always starts at phase zero. A level input adds half a turn to the sine address, which turns the tone upside down without disturbing the accumulator. A transmitter raises this input at the end of a transmission so the far receiver closes its squelch cleanly.

Samples leave through a valid/ready interface. A sample stays on the output, with valid held high, until the consumer accepts it. While the output slot is occupied, the generator keeps its real-time phase: a strobe that finds the slot full discards its sample instead of stalling the accumulator. All inputs are sampled only on the strobe edge.

Top module: `subtone_gen`

## Requirements
- R1: With `out_ready` high and transmit on, `out_valid` pulses for one cycle exactly once every CLK_HZ/SAMPLE_HZ clock cycles. `out_valid` rises only on the edge that follows a sample strobe, and the accumulator changes only on strobe edges.
- R2: Codes 1..47 select 47 frequencies in ascending order from 67.0 Hz to 254.1 Hz. Examples: code 1 = 67.0, code 13 = 100.0, code 25 = 151.4, code 40 = 210.7, code 47 = 254.1. The frequency measured from the samples (rising zero crossings over 4000 samples) is within 0.5 % of nominal.
- R3: Per-tone increment I = round(f·65536/(8000·4)), a 10-bit value scaled by 4. Number the samples after transmit starts n = 1, 2, .... Sample n equals round(511·sin(2π·a/256)) within 2 LSB, where a is the top 8 bits of (n·4·I + 32768·rev) mod 65536. Samples are 10-bit two's complement.
- R4: Holding `phase_rev` high while a tone runs shifts the waveform by 180 degrees from the next sample on. That sample is the negation of the unreversed one, within 2 LSB.
- R5: Releasing `phase_rev` restores the unreversed waveform from the next sample on. Reversal never resets the accumulator.
- R6: A tone-code change while transmitting takes effect at the next strobe. The phase continues from the accumulator's present value. This holds even when a reversal change lands on the same strobe.
- R7: With `tx_en` low, every sample is 0 regardless of `phase_rev`. The accumulator is cleared, so the next tone restarts at n = 1.
- R8: Codes 0 and 48..63 yield samples of 0 even with `tx_en` high, and clear the accumulator.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` stays unchanged across later strobes. Accepting the sample drops `out_valid` on the next edge when no strobe coincides with it.
- R10: During and after reset, and before the first strobe, `out_valid` is 0 and `out_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_code | input | 6 | Tone select; 0 and 48..63 mean no tone |
| tx_en | input | 1 | Transmit enable; low forces mid-scale output |
| phase_rev | input | 1 | Level request for a 180-degree phase reversal |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts the sample when high with valid |
| out_sample | output | 10 | Signed sine sample; 0 is mid-scale |

## Verification
Two things can act on the same sample strobe: a phase reversal and a tone-code change. Both alter the sine address of that sample. The bench changes the code from 13 to 25 and raises `phase_rev` between the same pair of samples. It then checks every following sample against its own phase model, which applies the new increment and the half-turn offset together. A wrong order or a lost accumulator value shows up as a mismatch against the model. Stalls that coincide with strobes are covered separately by holding `out_ready` low across two strobes.

// File: rtl/subtone_pkg.sv
package subtone_pkg;

  // Nominal frequency in tenths of a hertz for each code; 0 means no tone.
  function automatic int tone_tenths(input int code);
    case (code)
      1: return 670;   2: return 693;   3: return 719;   4: return 744;
      5: return 770;   6: return 797;   7: return 825;   8: return 854;
      9: return 885;   10: return 915;  11: return 948;  12: return 974;
      13: return 1000; 14: return 1035; 15: return 1072; 16: return 1109;
      17: return 1148; 18: return 1188; 19: return 1230; 20: return 1273;
      21: return 1318; 22: return 1365; 23: return 1413; 24: return 1462;
      25: return 1514; 26: return 1567; 27: return 1622; 28: return 1679;
      29: return 1738; 30: return 1773; 31: return 1799; 32: return 1835;
      33: return 1862; 34: return 1899; 35: return 1928; 36: return 1966;
      37: return 1995; 38: return 2035; 39: return 2065; 40: return 2107;
      41: return 2181; 42: return 2257; 43: return 2291; 44: return 2336;
      45: return 2418; 46: return 2503; 47: return 2541;
      default: return 0;
    endcase
  endfunction

  // Rounded accumulator step before the left shift by inc_shift.
  function automatic int tone_incr(input int tenths, input int sample_hz,
                                   input int acc_w, input int inc_shift);
    longint num;
    longint den;
    num = longint'(tenths) << acc_w;
    den = (longint'(sample_hz) * 10) << inc_shift;
    return int'((2 * num + den) / (2 * den));
  endfunction

  // Rational half-wave sine approximation, error well below one LSB at 10 bits.
  function automatic int sine_point(input int idx, input int addr_w, input int amp);
    int half;
    int x;
    int p;
    int den;
    int mag;
    half = 1 << (addr_w - 1);
    x    = idx % half;
    p    = x * (half - x);
    den  = 5 * half * half - 4 * p;
    mag  = (2 * amp * 16 * p + den) / (2 * den);
    return (idx >= half) ? -mag : mag;
  endfunction

endpackage

// File: rtl/subtone_prescaler.sv
module subtone_prescaler #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign stb = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (stb) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DIV - 1));
endmodule

// File: rtl/subtone_inc_rom.sv
module subtone_inc_rom
  import subtone_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int INC_W     = 10,
  parameter int SAMPLE_HZ = 8000,
  parameter int ACC_W     = 16,
  parameter int INC_SHIFT = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [INC_W-1:0]  inc,
  output logic              tone_ok
);
  localparam int ENTRIES = 1 << CODE_W;

  logic [INC_W-1:0] rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    localparam int STEP = tone_incr(tone_tenths(i), SAMPLE_HZ, ACC_W, INC_SHIFT);
    assign rom[i] = INC_W'(STEP);
  end

  assign inc     = rom[code];
  assign tone_ok = |inc;
endmodule

// File: rtl/subtone_phase.sv
module subtone_phase #(
  parameter int ACC_W     = 16,
  parameter int INC_W     = 10,
  parameter int INC_SHIFT = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              active,
  input  logic [INC_W-1:0]  inc,
  input  logic              rev,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD = ACC_W - INC_W - INC_SHIFT;
  localparam logic [ACC_W-1:0] HALF_TURN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_n;
  logic [ACC_W-1:0] phase;

  if (PAD > 0) begin : g_pad
    assign step = {{PAD{1'b0}}, inc, {INC_SHIFT{1'b0}}};
  end else begin : g_nopad
    assign step = ACC_W'({inc, {INC_SHIFT{1'b0}}});
  end

  assign acc_n = acc + step;
  assign phase = acc_n + (rev ? HALF_TURN : '0);
  assign addr  = phase[ACC_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (stb) acc <= active ? acc_n : '0;
  end

  assert_acc_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(acc));
  assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !active) |=> (acc == '0));
endmodule

// File: rtl/subtone_sine_rom.sv
module subtone_sine_rom
  import subtone_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SMP_W  = 10
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [SMP_W-1:0] value
);
  localparam int POINTS = 1 << ADDR_W;
  localparam int AMP    = (1 << (SMP_W - 1)) - 1;

  logic signed [SMP_W-1:0] rom [POINTS];

  for (genvar i = 0; i < POINTS; i++) begin : g_point
    localparam int V = sine_point(i, ADDR_W, AMP);
    assign rom[i] = SMP_W'(V);
  end

  assign value = rom[addr];
endmodule

// File: rtl/subtone_gen.sv
module subtone_gen #(
  parameter int CLK_HZ    = 4_000_000,
  parameter int SAMPLE_HZ = 8000,
  parameter int CODE_W    = 6,
  parameter int INC_W     = 10,
  parameter int INC_SHIFT = 2,
  parameter int ACC_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int SMP_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       tone_code,
  input  logic                    tx_en,
  input  logic                    phase_rev,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [SMP_W-1:0] out_sample
);
  localparam int DIV = CLK_HZ / SAMPLE_HZ;

  logic                    stb;
  logic [INC_W-1:0]        inc;
  logic                    tone_ok;
  logic                    active;
  logic [ADDR_W-1:0]       addr;
  logic signed [SMP_W-1:0] sine_val;
  logic                    slot_free;

  subtone_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .stb(stb)
  );

  subtone_inc_rom #(
    .CODE_W(CODE_W), .INC_W(INC_W), .SAMPLE_HZ(SAMPLE_HZ),
    .ACC_W(ACC_W), .INC_SHIFT(INC_SHIFT)
  ) u_inc (
    .code(tone_code), .inc(inc), .tone_ok(tone_ok)
  );

  assign active = tx_en && tone_ok;

  subtone_phase #(
    .ACC_W(ACC_W), .INC_W(INC_W), .INC_SHIFT(INC_SHIFT), .ADDR_W(ADDR_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .stb(stb), .active(active),
    .inc(inc), .rev(phase_rev), .addr(addr)
  );

  subtone_sine_rom #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_sine (
    .addr(addr), .value(sine_val)
  );

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (stb && slot_free) begin
      out_valid  <= 1'b1;
      out_sample <= active ? sine_val : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_valid_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(stb));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
  assert_idle_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && slot_free && !tx_en) |=> (out_sample == '0));
  assert_notone_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && slot_free && (tone_code == '0 || int'(tone_code) >= 48)) |=> (out_sample == '0));
endmodule

// File: tb/subtone_gen_tb.sv
module subtone_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 32000;
  localparam int TB_DIV     = TB_CLK_HZ / 8000;
  localparam int WINDOW     = 4000;
  localparam int LIMIT      = 180000;
  localparam int NVEC       = 5;
  localparam int VEC_CODE   [NVEC] = '{1, 13, 25, 40, 47};
  localparam int VEC_TENTHS [NVEC] = '{670, 1000, 1514, 2107, 2541};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [5:0]        tone_code = '0;
  logic              tx_en = 1'b0;
  logic              phase_rev = 1'b0;
  logic              out_ready = 1'b1;
  logic              out_valid;
  logic signed [9:0] out_sample;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_m = 0;
  int inc_m = 0;
  int last_t = 0;

  subtone_gen #(.CLK_HZ(TB_CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .tone_code(tone_code), .tx_en(tx_en),
    .phase_rev(phase_rev), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc >= LIMIT);
    errors = errors + 1;
    $display("FAIL watchdog actual %0d cycles expected below %0d", cyc, LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int incr_of(input int tenths);
    return $rtoi(real'(tenths) * 65536.0 / 320000.0 + 0.5);
  endfunction

  function automatic int model(input int acc, input bit rev);
    int a;
    real r;
    a = ((acc + (rev ? 32768 : 0)) % 65536) >> 8;
    r = 511.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic get_sample(output int s);
    do @(negedge clk); while (!out_valid);
    s = int'(out_sample);
    last_t = cyc;
  endtask

  task automatic model_run(input int n, input string req);
    int s;
    int e;
    for (int k = 0; k < n; k++) begin
      get_sample(s);
      acc_m = (acc_m + 4 * inc_m) % 65536;
      e = model(acc_m, phase_rev);
      chk(absi(s - e) <= 2, req, s, e);
    end
  endtask

  task automatic restart(input int code, input int tenths);
    int s;
    tx_en = 1'b0;
    get_sample(s);
    chk(s == 0, "R7", s, 0);
    tone_code = 6'(code);
    tx_en = 1'b1;
    acc_m = 0;
    inc_m = incr_of(tenths);
  endtask

  initial begin
    int s;
    int t0;
    int e;
    int ncross;
    int t_first;
    int t_last;
    int prev;
    real f_est;
    real f_nom;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    chk(out_sample == '0, "R10", int'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_sample == '0, "R10", int'(out_sample), 0);

    // R2: frequency vectors walked by one loop
    for (int v = 0; v < NVEC; v++) begin
      restart(VEC_CODE[v], VEC_TENTHS[v]);
      ncross = 0; t_first = 0; t_last = 0; prev = 0;
      for (int i = 0; i < WINDOW; i++) begin
        get_sample(s);
        if (prev < 0 && s >= 0) begin
          if (ncross == 0) t_first = i;
          t_last = i;
          ncross++;
        end
        prev = s;
      end
      f_nom = real'(VEC_TENTHS[v]) / 10.0;
      f_est = (t_last > t_first) ?
              real'(ncross - 1) * 8000.0 / real'(t_last - t_first) : 0.0;
      chk(f_est >= f_nom * 0.995 && f_est <= f_nom * 1.005, "R2",
          $rtoi(f_est * 10.0), VEC_TENTHS[v]);
    end

    // R1: strobe spacing
    get_sample(s); t0 = last_t;
    get_sample(s);
    chk(last_t - t0 == TB_DIV, "R1", last_t - t0, TB_DIV);

    // R3: exact waveform from phase 0
    restart(13, 1000);
    model_run(60, "R3");

    // R4: reversal, first reversed sample is the negated unreversed one
    phase_rev = 1'b1;
    get_sample(s);
    acc_m = (acc_m + 4 * inc_m) % 65536;
    e = model(acc_m, 1'b0);
    chk(absi(s + e) <= 2, "R4", s, -e);
    model_run(30, "R4");

    // R5: release keeps the accumulator running
    phase_rev = 1'b0;
    model_run(25, "R5");

    // R6: code change and reversal on the same strobe
    tone_code = 6'd25;
    phase_rev = 1'b1;
    inc_m = incr_of(1514);
    model_run(40, "R6");
    phase_rev = 1'b0;
    model_run(10, "R6");

    // R8: no-tone codes with transmit on
    tone_code = 6'd55;
    for (int k = 0; k < 4; k++) begin get_sample(s); chk(s == 0, "R8", s, 0); end
    tone_code = 6'd0;
    for (int k = 0; k < 4; k++) begin get_sample(s); chk(s == 0, "R8", s, 0); end
    tone_code = 6'd13; acc_m = 0; inc_m = incr_of(1000);
    model_run(10, "R8");

    // R7: transmit off, reversal request has no effect, tone restarts at n=1
    tx_en = 1'b0; phase_rev = 1'b1;
    for (int k = 0; k < 4; k++) begin get_sample(s); chk(s == 0, "R7", s, 0); end
    phase_rev = 1'b0; tx_en = 1'b1; acc_m = 0;
    model_run(10, "R7");

    // R9: back-pressure across two strobes
    out_ready = 1'b0;
    get_sample(s);
    e = 1;
    for (int k = 0; k < 2 * TB_DIV; k++) begin
      @(negedge clk);
      if (!out_valid || int'(out_sample) != s) e = 0;
    end
    chk(e == 1, "R9", int'(out_sample), s);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule